// File: doc/BRIEF.md
# SATA Host-to-Device Command Frame Decoder

This block takes one host-to-device register frame, delivered a byte at a time with an explicit byte index, together with the command-header word that came with it. Once the byte flagged as the last one has been taken in, the block checks the frame type byte. A frame whose type byte is wrong produces an error pulse. Any other frame produces a valid pulse together with the fields a storage controller's command engine needs: whether the frame is a command or a control frame, the command class, the opcode, the starting block address, the sector count, the transfer direction and the length of the command frame.

The byte map for the block address and the count is not fixed. It depends on the command class. Queued and 48-bit transfers take a 48-bit address from six bytes. Queued transfers take their count from a split pair of bytes, and 48-bit transfers take it from bytes 12 and 13. Every other command uses the 28-bit form. When a transfer command carries a count of zero, the count is passed through as zero and a separate flag is raised, so that later stages can apply the full-range rule.

The decoded fields sit in output registers. They change only when a later frame decodes without error.

Top module: `fis_cmd_decoder`

## Requirements
- R1: When the byte at index 0 is not 0x27, the block raises `dec_err` for one cycle and keeps `dec_valid` low. Every decoded output keeps the value it held before that frame.
- R2: When bit 7 of byte 1 is set, the frame is a command and `is_cmd` is 1. Otherwise the frame is a control frame. For a control frame, `soft_reset` takes bit 2 of byte 15, `cmd_class` is 4, and `opcode`, `lba`, `sect_count`, `count_zero` and `is_write` are all 0. `soft_reset` is 0 for every command frame.
- R3: The opcode is byte 2. `cmd_class` is set by the opcode as follows: 0x60 and 0x61 give 0 (queued); 0x25 and 0x35 give 1 (48-bit); 0xC8 and 0xCA give 2 (28-bit); 0xE7 and 0xEA give 3 (flush). Any other opcode gives 4.
- R4: For class 0, `lba` is formed from bytes 10, 9, 8, 6, 5 and 4, from most significant to least significant. `sect_count` is byte 11 (high byte) followed by byte 3 (low byte).
- R5: For class 1, `lba` uses the same six bytes as class 0. `sect_count` is byte 13 (high byte) followed by byte 12 (low byte).
- R6: For classes 2, 3 and 4, `lba` is the low nibble of byte 7 followed by bytes 6, 5 and 4, and the upper 20 bits are zero. `sect_count` is byte 12 with a zero high byte. The high nibble of byte 7 and bytes 8 to 11 have no effect.
- R7: `is_write` is 1 only for opcodes 0xCA, 0x35 and 0x61. It is 0 for every other opcode.
- R8: `fis_len` equals bits [4:0] of `hdr_flags` times 4. The other header bits have no effect on it.
- R9: `count_zero` is 1 exactly when the class is 0, 1 or 2 and the decoded count is 0. For classes 3 and 4 it is 0.
- R10: `dec_valid` or `dec_err` is high for the single cycle that follows the clock edge taking in the byte marked `in_last`. Between valid pulses, every decoded output holds its value.
- R11: A byte written at index 0 clears every other stored byte. Any byte that a frame does not send therefore decodes as zero.
- R12: After reset, all outputs are 0, except `cmd_class`, which is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A frame byte is present |
| in_idx | input | 5 | Byte index within the frame |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| hdr_flags | input | 16 | Command-header flags word, sampled with the last byte |
| dec_valid | output | 1 | One-cycle pulse: decoded fields updated |
| dec_err | output | 1 | One-cycle pulse: frame type rejected |
| is_cmd | output | 1 | Frame is a command (1) or a control frame (0) |
| soft_reset | output | 1 | Control frame requests a soft reset |
| cmd_class | output | 3 | 0 queued, 1 48-bit, 2 28-bit, 3 flush, 4 other |
| opcode | output | 8 | Command opcode |
| lba | output | 48 | Starting block address |
| sect_count | output | 16 | Sector count as carried in the frame |
| count_zero | output | 1 | Transfer command carried a zero count |
| is_write | output | 1 | Transfer direction is host to device |
| fis_len | output | 7 | Command frame length in bytes |

## Verification
There are two register stages between the last byte and the results. The byte store and a done flag both load on the edge that takes in the last byte. The output registers load on the next edge. Every result, `dec_err` included, is therefore due one clock after that edge. The bench drives each byte on a falling edge, lowers `in_valid` on the falling edge that follows the last byte, and samples 1 ns after the next rising edge. The hold checks then look at the same outputs again several cycles later, which confirms that the pulse has ended and that the fields have not moved.

// File: rtl/fisdec_pkg.sv
package fisdec_pkg;
  localparam logic [7:0] FRAME_H2D   = 8'h27;
  localparam logic [7:0] OP_RD_Q     = 8'h60;
  localparam logic [7:0] OP_WR_Q     = 8'h61;
  localparam logic [7:0] OP_RD_EXT   = 8'h25;
  localparam logic [7:0] OP_WR_EXT   = 8'h35;
  localparam logic [7:0] OP_RD_28    = 8'hC8;
  localparam logic [7:0] OP_WR_28    = 8'hCA;
  localparam logic [7:0] OP_FLUSH    = 8'hE7;
  localparam logic [7:0] OP_FLUSH_X  = 8'hEA;

  typedef enum logic [2:0] {
    CLS_QUEUED = 3'd0,
    CLS_EXT48  = 3'd1,
    CLS_LBA28  = 3'd2,
    CLS_FLUSH  = 3'd3,
    CLS_OTHER  = 3'd4
  } cmd_class_t;
endpackage

// File: rtl/fisdec_capture.sv
module fisdec_capture #(
  parameter int NBYTES  = 20,
  parameter int IDX_W   = 5,
  parameter int FLAGS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [IDX_W-1:0]      in_idx,
  input  logic [7:0]            in_data,
  input  logic                  in_last,
  input  logic [FLAGS_W-1:0]    in_flags,
  output logic [NBYTES*8-1:0]   frame_q,
  output logic [FLAGS_W-1:0]    flags_q,
  output logic                  done_q
);
  logic start_frame;
  assign start_frame = in_valid && (in_idx == '0);

  // One register per byte slot; index 0 restarts the frame.
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        frame_q[g*8 +: 8] <= '0;
      else if (in_valid && (in_idx == IDX_W'(g)))
        frame_q[g*8 +: 8] <= in_data;
      else if (start_frame)
        frame_q[g*8 +: 8] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= in_valid && in_last;
      if (in_valid && in_last)
        flags_q <= in_flags;
    end
  end

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_idx == '0 && in_data == 8'h00) |=> (frame_q == '0));
endmodule

// File: rtl/fisdec_classify.sv
module fisdec_classify
  import fisdec_pkg::*;
(
  input  logic [7:0] op,
  output cmd_class_t cls,
  output logic       wr
);
  always_comb begin
    unique case (op)
      OP_RD_Q, OP_WR_Q:       cls = CLS_QUEUED;
      OP_RD_EXT, OP_WR_EXT:   cls = CLS_EXT48;
      OP_RD_28, OP_WR_28:     cls = CLS_LBA28;
      OP_FLUSH, OP_FLUSH_X:   cls = CLS_FLUSH;
      default:                cls = CLS_OTHER;
    endcase
  end

  assign wr = (op == OP_WR_Q) || (op == OP_WR_EXT) || (op == OP_WR_28);
endmodule

// File: rtl/fisdec_fields.sv
module fisdec_fields
  import fisdec_pkg::*;
#(
  parameter int NBYTES = 20,
  parameter int LBA_W  = 48,
  parameter int CNT_W  = 16
) (
  input  logic [NBYTES*8-1:0] frame,
  input  cmd_class_t          cls,
  output logic [LBA_W-1:0]    lba,
  output logic [CNT_W-1:0]    cnt,
  output logic                cnt_zero
);
  function automatic logic [7:0] byte_at(input int i);
    return frame[i*8 +: 8];
  endfunction

  logic [LBA_W-1:0] lba_wide, lba_short;
  logic [CNT_W-1:0] cnt_split, cnt_ext, cnt_short;

  assign lba_wide  = LBA_W'({byte_at(10), byte_at(9), byte_at(8),
                             byte_at(6), byte_at(5), byte_at(4)});
  assign lba_short = LBA_W'({byte_at(7)[3:0], byte_at(6), byte_at(5), byte_at(4)});
  assign cnt_split = CNT_W'({byte_at(11), byte_at(3)});
  assign cnt_ext   = CNT_W'({byte_at(13), byte_at(12)});
  assign cnt_short = CNT_W'(byte_at(12));

  always_comb begin
    case (cls)
      CLS_QUEUED: begin lba = lba_wide;  cnt = cnt_split; end
      CLS_EXT48:  begin lba = lba_wide;  cnt = cnt_ext;   end
      default:    begin lba = lba_short; cnt = cnt_short; end
    endcase
    cnt_zero = (cls == CLS_QUEUED || cls == CLS_EXT48 || cls == CLS_LBA28)
               && (cnt == '0);
  end
endmodule

// File: rtl/fis_cmd_decoder.sv
module fis_cmd_decoder
  import fisdec_pkg::*;
#(
  parameter int NBYTES  = 20,
  parameter int IDX_W   = 5,
  parameter int FLAGS_W = 16,
  parameter int CFL_W   = 5,
  parameter int LBA_W   = 48,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic [FLAGS_W-1:0] hdr_flags,
  output logic               dec_valid,
  output logic               dec_err,
  output logic               is_cmd,
  output logic               soft_reset,
  output logic [2:0]         cmd_class,
  output logic [7:0]         opcode,
  output logic [LBA_W-1:0]   lba,
  output logic [CNT_W-1:0]   sect_count,
  output logic               count_zero,
  output logic               is_write,
  output logic [CFL_W+1:0]   fis_len
);
  localparam int LEN_W = CFL_W + 2;

  logic [NBYTES*8-1:0] frame;
  logic [FLAGS_W-1:0]  flags;
  logic                frame_done;
  cmd_class_t          cls_c;
  logic                wr_c;
  logic [LBA_W-1:0]    lba_c;
  logic [CNT_W-1:0]    cnt_c;
  logic                cz_c;

  fisdec_capture #(.NBYTES(NBYTES), .IDX_W(IDX_W), .FLAGS_W(FLAGS_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
    .in_data(in_data), .in_last(in_last), .in_flags(hdr_flags),
    .frame_q(frame), .flags_q(flags), .done_q(frame_done)
  );

  fisdec_classify u_cls (.op(frame[23:16]), .cls(cls_c), .wr(wr_c));

  fisdec_fields #(.NBYTES(NBYTES), .LBA_W(LBA_W), .CNT_W(CNT_W)) u_fld (
    .frame(frame), .cls(cls_c), .lba(lba_c), .cnt(cnt_c), .cnt_zero(cz_c)
  );

  logic type_ok, cmd_bit, srst_bit;
  assign type_ok  = (frame[7:0] == FRAME_H2D);
  assign cmd_bit  = frame[15];
  assign srst_bit = frame[15*8 + 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_err    <= 1'b0;
      is_cmd     <= 1'b0;
      soft_reset <= 1'b0;
      cmd_class  <= CLS_OTHER;
      opcode     <= '0;
      lba        <= '0;
      sect_count <= '0;
      count_zero <= 1'b0;
      is_write   <= 1'b0;
      fis_len    <= '0;
    end else begin
      dec_valid <= frame_done && type_ok;
      dec_err   <= frame_done && !type_ok;
      if (frame_done && type_ok) begin
        is_cmd  <= cmd_bit;
        fis_len <= LEN_W'({flags[CFL_W-1:0], 2'b00});
        if (cmd_bit) begin
          soft_reset <= 1'b0;
          cmd_class  <= cls_c;
          opcode     <= frame[23:16];
          lba        <= lba_c;
          sect_count <= cnt_c;
          count_zero <= cz_c;
          is_write   <= wr_c;
        end else begin
          soft_reset <= srst_bit;
          cmd_class  <= CLS_OTHER;
          opcode     <= '0;
          lba        <= '0;
          sect_count <= '0;
          count_zero <= 1'b0;
          is_write   <= 1'b0;
        end
      end
    end
  end

  // R1
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (!dec_valid && $stable(lba) && $stable(cmd_class) && $stable(fis_len)));
  // R10
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> ($stable(lba) && $stable(sect_count) && $stable(opcode) && $stable(is_cmd)));
  // R10
  pulse_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid || dec_err) |-> $past(frame_done));
  // R2
  ctrl_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !is_cmd) |-> (cmd_class == 3'd4 && lba == '0 && !is_write && !count_zero));
  // R2
  cmd_no_srst_chk: assert property (@(posedge clk) disable iff (rst)
    is_cmd |-> !soft_reset);
  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    count_zero |-> (sect_count == '0 && cmd_class <= 3'd2));
  // R7
  write_class_chk: assert property (@(posedge clk) disable iff (rst)
    is_write |-> (cmd_class <= 3'd2));
endmodule

// File: tb/sim_fis_cmd_decoder.sv
module sim_fis_cmd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [4:0] in_idx = '0;
  logic [7:0] in_data = '0;
  logic [15:0] hdr_flags = '0;
  logic dec_valid, dec_err, is_cmd, soft_reset, count_zero, is_write;
  logic [2:0] cmd_class;
  logic [7:0] opcode;
  logic [47:0] lba;
  logic [15:0] sect_count;
  logic [6:0] fis_len;

  int tests = 0, fails = 0;
  logic [7:0] fb [20];

  always #5 clk = ~clk;

  fis_cmd_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
    .in_data(in_data), .in_last(in_last), .hdr_flags(hdr_flags),
    .dec_valid(dec_valid), .dec_err(dec_err), .is_cmd(is_cmd),
    .soft_reset(soft_reset), .cmd_class(cmd_class), .opcode(opcode),
    .lba(lba), .sect_count(sect_count), .count_zero(count_zero),
    .is_write(is_write), .fis_len(fis_len)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic base_frame(input logic [7:0] op);
    for (int i = 0; i < 20; i++) fb[i] = 8'h00;
    fb[0] = 8'h27; fb[1] = 8'h80; fb[2] = op;
    fb[3] = 8'h08; fb[4] = 8'h11; fb[5] = 8'h22; fb[6] = 8'h33;
    fb[7] = 8'h4F; fb[8] = 8'h44; fb[9] = 8'h55; fb[10] = 8'h66;
    fb[11] = 8'h01; fb[12] = 8'h99; fb[13] = 8'h77;
  endtask

  // Result due one edge after the edge that takes the last byte.
  task automatic send(input int n, input logic [15:0] fl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_idx = 5'(i); in_data = fb[i];
      in_last = (i == n - 1); hdr_flags = fl;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R12 valid", dec_valid, 0); chk("R12 err", dec_err, 0);
    chk("R12 class", cmd_class, 4); chk("R12 lba", lba, 0);
    chk("R12 count", sect_count, 0); chk("R12 len", fis_len, 0);
  endtask

  task automatic t_queued;
    base_frame(8'h60); send(20, 16'h0005);
    chk("R10 valid", dec_valid, 1); chk("R3 class q", cmd_class, 0);
    chk("R4 lba", lba, 48'h665544332211); chk("R4 count", sect_count, 16'h0108);
    chk("R7 read", is_write, 0); chk("R8 len", fis_len, 20);
    chk("R2 cmd", is_cmd, 1); chk("R9 nz", count_zero, 0);
    base_frame(8'h61); send(20, 16'h0005);
    chk("R7 q write", is_write, 1); chk("R3 opcode", opcode, 8'h61);
  endtask

  task automatic t_ext48;
    base_frame(8'h35); fb[12] = 8'h00; fb[13] = 8'h00; send(20, 16'h0005);
    chk("R3 class ext", cmd_class, 1); chk("R5 lba", lba, 48'h665544332211);
    chk("R5 count0", sect_count, 0); chk("R9 zero ext", count_zero, 1);
    chk("R7 ext write", is_write, 1);
    base_frame(8'h25); fb[13] = 8'h12; fb[12] = 8'h34; send(20, 16'h0005);
    chk("R5 count", sect_count, 16'h1234); chk("R7 ext read", is_write, 0);
  endtask

  task automatic t_lba28;
    base_frame(8'hC8); fb[7] = 8'hAB; send(20, 16'hFC05);
    chk("R3 class 28", cmd_class, 2); chk("R6 lba", lba, 48'h0B332211);
    chk("R6 count", sect_count, 16'h0099); chk("R8 upper ignored", fis_len, 20);
    base_frame(8'hCA); fb[12] = 8'h00; send(20, 16'h001F);
    chk("R9 zero 28", count_zero, 1); chk("R7 28 write", is_write, 1);
    chk("R8 max len", fis_len, 124);
  endtask

  task automatic t_flush_other;
    base_frame(8'hE7); fb[12] = 8'h00; send(20, 16'h0005);
    chk("R3 class flush", cmd_class, 3); chk("R9 flush no flag", count_zero, 0);
    chk("R6 flush lba", lba, 48'h0F332211);
    base_frame(8'hEC); send(20, 16'h0005);
    chk("R3 class other", cmd_class, 4); chk("R7 other", is_write, 0);
  endtask

  task automatic t_control;
    base_frame(8'h00); fb[1] = 8'h00; fb[15] = 8'h04; send(20, 16'h0005);
    chk("R2 ctrl", is_cmd, 0); chk("R2 srst", soft_reset, 1);
    chk("R2 ctrl lba", lba, 0); chk("R2 ctrl class", cmd_class, 4);
    fb[15] = 8'hFB; send(20, 16'h0005);
    chk("R2 no srst", soft_reset, 0);
  endtask

  task automatic t_error;
    base_frame(8'h25); send(20, 16'h0005);
    base_frame(8'hC8); fb[0] = 8'h34; send(20, 16'h0002);
    chk("R1 err", dec_err, 1); chk("R1 no valid", dec_valid, 0);
    chk("R1 lba held", lba, 48'h665544332211); chk("R1 len held", fis_len, 20);
    chk("R1 class held", cmd_class, 1);
  endtask

  task automatic t_hold;
    base_frame(8'h60); send(20, 16'h0005);
    repeat (3) @(posedge clk); #1;
    chk("R10 pulse ends", dec_valid, 0); chk("R10 lba hold", lba, 48'h665544332211);
    chk("R10 count hold", sect_count, 16'h0108);
  endtask

  task automatic t_short;
    base_frame(8'hC8); send(20, 16'h0005);
    base_frame(8'hC8); send(8, 16'h0005);
    chk("R11 count cleared", sect_count, 0); chk("R11 zero flag", count_zero, 1);
    chk("R11 lba", lba, 48'h0F332211);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset(); t_queued(); t_ext48(); t_lba28(); t_flush_other();
    t_control(); t_error(); t_hold(); t_short();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule